// File: doc/BRIEF.md
# Serial CRC-32 Generator and Checker

This block computes a 32-bit cyclic redundancy check one bit per clock. The remainder register is a linear feedback shift register that performs modulo-2 division by the CRC-32 generator 0x04C11DB7. A clock enable gates every change of the register. A single mode input chooses between two jobs.

In compute mode each serial input bit is folded into the remainder and the same bit goes straight through to the serial output. In shift-out mode the register stops absorbing input and drains its 32 remainder bits, most significant first, onto the same serial output, so the checksum directly follows the message. A receiver runs the message and the appended checksum through the same block in compute mode. An all-zero register afterwards means no error was detected, and the error output shows any non-zero residue.

The register starts from zero and no inversion is applied on input or output, so the zero-residue test holds exactly.

Top module: `serial_crc32`

## Requirements
- R1: Holding `rst_n` low at a rising clock edge clears the remainder register to all zeros, so `crc_err` reads 0 after reset.
- R2: While `shift_en` is 0, the remainder register does not change in either mode, and in shift-out mode `ser_out` keeps presenting the same bit.
- R3: With `calc_mode` = 1 (compute mode) and `shift_en` = 1, each clock folds `ser_in` into the remainder. The feedback is `ser_in` XOR the register MSB. The register shifts left, and the feedback is XORed in at the set bits of 0x04C11DB7. After a message of N bits, the register equals the remainder of (message polynomial, first bit as highest power) times x^32, divided by x^32 + 0x04C11DB7.
- R4: With `calc_mode` = 1, `ser_out` equals `ser_in` in the same cycle.
- R5: With `calc_mode` = 0 (shift-out mode), `ser_out` presents register bit 31. Each enabled clock shifts the register left by one, with 0 entering at bit 0. The remainder therefore leaves MSB first, and after 32 enabled cycles the register is zero.
- R6: `crc_err` is 1 exactly when the remainder register is non-zero.
- R7: Feeding a message and then its 32 remainder bits (MSB first) in compute mode from reset leaves the register at zero with `crc_err` = 0. If any single bit of that stream is inverted, `crc_err` = 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | Clock enable for the remainder register |
| calc_mode | input | 1 | 1 = compute and pass through, 0 = shift the remainder out |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial output: `ser_in` in compute mode, remainder MSB in shift-out mode |
| crc_err | output | 1 | High when the remainder register is non-zero |

## Verification
Every 8-bit message is swept exhaustively, so each low-order feedback path and each carry of the feedback into high bits is exercised. Walking single-one messages of 40 bits isolate the impulse response of each bit position. All-ones messages of lengths 1 to 40 stress long runs of feedback. A handful of arithmetically generated 64-bit words cover dense, mixed data.

For each message, the drained remainder is compared with a long-hand polynomial division. An enable gap in the middle of the drain tells holding apart from shifting. The message with its checksum is then replayed to confirm a zero residue. Finally, one bit is inverted at a position that changes per message, to confirm the error flag.

// File: rtl/crc_ser_pkg.sv
// Package: shared constants and mode encoding for the serial CRC-32 unit.
// Assumes: generator written without its x^32 term, MSB-first bit order.
package crc_ser_pkg;
    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_CALC  = 1'b1
    } crc_mode_e;
endpackage

// File: rtl/crc_ser_lfsr.sv
// Module: remainder register of the serial CRC, one LFSR step per enabled clock.
// Compute mode folds din into the register. Shift-out mode only shifts, with zero entering at bit 0.
// Assumes: POLY holds the generator without its leading term.
module crc_ser_lfsr #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   POLY = 32'h04C1_1DB7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         calc,
    input  logic         din,
    output logic [W-1:0] crc_q
);
    logic         fb;
    logic [W-1:0] crc_d;

    // Feedback: only active in compute mode.
    assign fb = calc & (din ^ crc_q[W-1]);

    // Next-state per bit: shifted neighbour plus feedback at each tap.
    generate
        for (genvar i = 0; i < W; i++) begin : g_tap
            if (i == 0) begin : g_lsb
                assign crc_d[i] = fb & POLY[i];
            end else begin : g_mid
                assign crc_d[i] = crc_q[i-1] ^ (fb & POLY[i]);
            end
        end
    endgenerate

    // Register update: synchronous clear, otherwise advance when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (adv) begin
            crc_q <= crc_d;
        end
    end
endmodule

// File: rtl/crc_ser_outmux.sv
// Module: serial output select, pass-through data or remainder MSB.
// Assumes: calc = 1 means compute mode.
module crc_ser_outmux (
    input  logic calc,
    input  logic din,
    input  logic rem_msb,
    output logic dout
);
    // Output select by mode.
    always_comb begin
        dout = calc ? din : rem_msb;
    end
endmodule

// File: rtl/crc_ser_zero.sv
// Module: non-zero detector on the remainder register.
// Assumes: flag is meaningful once all message and checksum bits are in.
module crc_ser_zero #(
    parameter int W = 32
) (
    input  logic [W-1:0] vec,
    output logic         nonzero
);
    // OR-reduction of all remainder bits.
    always_comb begin
        nonzero = |vec;
    end
endmodule

// File: rtl/serial_crc32.sv
// Module: bit-serial CRC-32 generator/checker (top).
// Compute mode: absorbs ser_in and forwards it. Shift-out mode: drains the remainder MSB first.
// Assumes: synchronous active-low reset, zero start value, no output inversion.
module serial_crc32
    import crc_ser_pkg::*;
#(
    parameter int           W    = CRC_W,
    parameter logic [W-1:0] POLY = CRC_POLY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic calc_mode,
    input  logic ser_in,
    output logic ser_out,
    output logic crc_err
);
    logic [W-1:0] crc_q;
    logic         calc;

    assign calc = (calc_mode == MODE_CALC);

    crc_ser_lfsr #(.W(W), .POLY(POLY)) lfsr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (shift_en),
        .calc  (calc),
        .din   (ser_in),
        .crc_q (crc_q)
    );

    crc_ser_outmux outmux_i (
        .calc    (calc),
        .din     (ser_in),
        .rem_msb (crc_q[W-1]),
        .dout    (ser_out)
    );

    crc_ser_zero #(.W(W)) zero_i (
        .vec     (crc_q),
        .nonzero (crc_err)
    );
endmodule

// File: rtl/crc_ser_checker.sv
// Module: assertion checker for serial_crc32, attached by bind.
// Assumes: crc_q is the internal remainder register of the top.
module crc_ser_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         shift_en,
    input logic         calc_mode,
    input logic         ser_in,
    input logic         ser_out,
    input logic         crc_err,
    input logic [W-1:0] crc_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (crc_q == '0));

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(crc_q));

    assert_zero_stays_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && calc_mode && !ser_in && crc_q == '0) |=> (crc_q == '0));

    assert_pass_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
        calc_mode |-> (ser_out == ser_in));

    assert_drain_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !calc_mode) |=> (crc_q[0] == 1'b0 && crc_q[W-1:1] == $past(crc_q[W-2:0])));

    assert_drain_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !calc_mode |-> (ser_out == crc_q[W-1]));

    assert_err_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_err |-> (crc_q == '0));
endmodule

bind serial_crc32 crc_ser_checker #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .calc_mode (calc_mode),
    .ser_in    (ser_in),
    .ser_out   (ser_out),
    .crc_err   (crc_err),
    .crc_q     (crc_q)
);

// File: tb/serial_crc32_tb_top.sv
// Bench: sweeps messages, compares the drained remainder with long-hand division,
// then checks the zero residue and single-bit error detection.
module serial_crc32_tb_top;
    localparam logic [32:0] GEN = 33'h1_04C1_1DB7;
    localparam int MAXB = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_en = 1'b0;
    logic calc_mode = 1'b1;
    logic ser_in = 1'b0;
    logic ser_out;
    logic crc_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_crc32 dut_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .calc_mode(calc_mode),
        .ser_in(ser_in), .ser_out(ser_out), .crc_err(crc_err)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Long-hand modulo-2 division of message * x^32 by the generator.
    function automatic logic [31:0] div_ref(input logic [0:MAXB-1] m, input int n);
        logic [0:MAXB+31] a;
        logic [31:0] r;
        a = '0;
        for (int i = 0; i < n; i++) a[i] = m[i];
        for (int i = 0; i < n; i++)
            if (a[i])
                for (int j = 0; j <= 32; j++) a[i+j] = a[i+j] ^ GEN[32-j];
        for (int k = 0; k < 32; k++) r[31-k] = a[n+k];
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; shift_en = 1'b0; calc_mode = 1'b1; ser_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 err after reset", crc_err, 1'b0);
    endtask

    task automatic feed(input logic b);
        @(negedge clk);
        shift_en = 1'b1; calc_mode = 1'b1; ser_in = b;
        #1 check("R4 pass-through", ser_out, b);
    endtask

    task automatic run_msg(input logic [0:MAXB-1] m, input int n, input int seed);
        logic [31:0] rem;
        int flip;
        rem = div_ref(m, n);
        do_reset();
        for (int i = 0; i < n; i++) feed(m[i]);
        @(negedge clk);
        shift_en = 1'b0;
        #1 check("R6 err after message", crc_err, rem != 0);
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            shift_en = 1'b1; calc_mode = 1'b0; ser_in = ~ser_in;
            #1 check("R3/R5 drained bit", ser_out, rem[31-k]);
            if (k == 13) begin
                shift_en = 1'b0;
                for (int g = 0; g < 3; g++) begin
                    @(negedge clk);
                    #1 check("R2 hold while disabled", ser_out, rem[31-k]);
                end
                shift_en = 1'b1;
            end
        end
        @(negedge clk);
        shift_en = 1'b0;
        #1 check("R5 zero after 32 drains", crc_err, 1'b0);
        // Receiver: message plus checksum gives zero residue.
        do_reset();
        for (int i = 0; i < n; i++) feed(m[i]);
        for (int k = 0; k < 32; k++) feed(rem[31-k]);
        @(negedge clk);
        shift_en = 1'b0;
        #1 check("R7 clean residue", crc_err, 1'b0);
        // Single inverted bit must be flagged.
        flip = seed % (n + 32);
        do_reset();
        for (int i = 0; i < n; i++) feed(m[i] ^ (i == flip));
        for (int k = 0; k < 32; k++) feed(rem[31-k] ^ ((n + k) == flip));
        @(negedge clk);
        shift_en = 1'b0;
        #1 check("R7 single-bit error flagged", crc_err, 1'b1);
    endtask

    initial begin
        logic [0:MAXB-1] m;
        logic [63:0] w;
        int run;
        run = 0;
        // Exhaustive 8-bit messages.
        for (int v = 0; v < 256; v++) begin
            m = '0;
            for (int i = 0; i < 8; i++) m[i] = v[7-i];
            run_msg(m, 8, run); run++;
        end
        // Walking single one in 40 bits.
        for (int p = 0; p < 40; p++) begin
            m = '0; m[p] = 1'b1;
            run_msg(m, 40, run * 7); run++;
        end
        // All-ones of each length.
        for (int n = 1; n <= 40; n++) begin
            m = '0;
            for (int i = 0; i < n; i++) m[i] = 1'b1;
            run_msg(m, n, run * 3); run++;
        end
        // Arithmetic 64-bit words.
        w = 64'h0123_4567_89AB_CDEF;
        for (int t = 0; t < 8; t++) begin
            w = w * 64'd6364136223846793005 + 64'd1442695040888963407;
            m = '0;
            for (int i = 0; i < 64; i++) m[i] = w[63-i];
            run_msg(m, 64, run * 11); run++;
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule